// File: doc/BRIEF.md
# Baud Rate Enable Generator

This block turns one master time base into the two strobes a serial port needs: a 16x sample strobe for the receiver and a 1x bit strobe for the transmitter. An integer prescaler divides the master source by a value between 2 and 64. A free-running binary counter behind it offers eight power-of-two taps, from divide by 1 up to divide by 128. The selected tap gives the 16x strobe. A final divide by 16 gives the 1x strobe and a square 1x bit clock with equal high and low times.

The master source is either the system clock or an external pin. The external pin is synchronised and edge detected; it is never used as a clock. For synchronous links the 1x bit clock pin can be driven by the block, or released and used as an input. In input mode, rising edges on that pin set the 1x strobe. Everything runs in the single `clk` domain, and every strobe is one cycle wide.

Any configuration write clears all divider state. The first 16x strobe after a write therefore marks a full period, never a cut-short one.

Top module: `baud_tap_gen`

## Requirements
- R1: With the system clock as source, divisor D and tap T, `tick16` pulses every D·2^T cycles, for every D from 2 to 64.
- R2: `cfg_div` is read as the divisor itself. Values below 2 act as 2 and values above 64 act as 64.
- R3: `cfg_tap` value T (0 to 7) multiplies the 16x period by 2^T.
- R4: `tick16` and `tick1` are high for exactly one cycle per pulse.
- R5: In output mode, `tick1` pulses every 16 `tick16` periods, in the same cycle as a `tick16` pulse. `bclk_out` is high for 8 and low for 8 `tick16` periods, and rises together with `tick1`.
- R6: A cycle with `cfg_we` high loads `cfg_div`/`cfg_tap` and clears all counters and `bclk_out`. The first `tick16` comes exactly D·2^T cycles after that write edge, and the first `tick1` exactly 8·D·2^T cycles after it.
- R7: With `src_ext_sel` high, the prescaler counts rising edges of `ext_src_in` instead of system clock cycles. With that input held steady, no `tick16` occurs.
- R8: With `bclk_dir_in` high, `bclk_oe` and `bclk_out` are low and the internal 1x path does not pulse `tick1`. A rising edge on `bclk_in` pulses `tick1` on the third clock edge after the change.
- R9: After reset, `tick16`, `tick1` and `bclk_out` are low, and `bclk_oe` is high while `bclk_dir_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ext_sel | input | 1 | 1: master source is `ext_src_in`; 0: system clock |
| ext_src_in | input | 1 | External master source pin (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 7 | Prescaler divisor (clamped to 2..64) |
| cfg_tap | input | 3 | Binary tap select, divide by 2^value |
| bclk_dir_in | input | 1 | 1: 1x bit clock pin is an input |
| bclk_in | input | 1 | External 1x bit clock (asynchronous) |
| tick16 | output | 1 | 16x receive sample strobe |
| tick1 | output | 1 | 1x transmit bit strobe |
| bclk_out | output | 1 | 50% duty 1x bit clock for the pin |
| bclk_oe | output | 1 | Output enable for the bit clock pin |

## Verification
The bench builds the block with its default parameters: a 7-bit divisor field, a 2 to 64 range, three tap bits and a ratio of 16. With these values, every legal divisor can be swept at tap 0. Every tap can be swept at two divisors. Out-of-range divisor codes on both sides of the range can be driven. Expected periods, first-pulse latencies and high times are computed as products of D, 2^T and 16. The external source runs at a known edge rate, so its expected period is also a plain product.

// File: rtl/baud_tap_gen.sv
module baud_tap_gen #(
  parameter int DIV_W   = 7,
  parameter int TAP_W   = 3,
  parameter int MIN_DIV = 2,
  parameter int MAX_DIV = 64,
  parameter int SUB     = 16,
  parameter int DEF_DIV = 2,
  parameter int DEF_TAP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_ext_sel,
  input  logic             ext_src_in,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [TAP_W-1:0] cfg_tap,
  input  logic             bclk_dir_in,
  input  logic             bclk_in,
  output logic             tick16,
  output logic             tick1,
  output logic             bclk_out,
  output logic             bclk_oe
);
  localparam int PCNT_W = $clog2(MAX_DIV);
  localparam int NTAP   = 1 << TAP_W;
  localparam int TCNT_W = NTAP - 1;
  localparam int SUB_W  = $clog2(SUB);
  localparam logic [DIV_W-1:0]  MIN_V = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0]  MAX_V = DIV_W'(MAX_DIV);
  localparam logic [PCNT_W-1:0] LO_RL = PCNT_W'(MIN_DIV - 1);
  localparam logic [PCNT_W-1:0] HI_RL = PCNT_W'(MAX_DIV - 1);

  logic [PCNT_W-1:0] reload, pcnt, wr_reload;
  logic [TAP_W-1:0]  tap;
  logic [TCNT_W-1:0] tcnt, tap_mask;
  logic [SUB_W-1:0]  cnt16;
  logic              bclk_q;
  logic [2:0]        xs, bs;
  logic              m_en, pre_hit, hit16, half_hit;

  always_comb begin
    if (cfg_div < MIN_V)      wr_reload = LO_RL;
    else if (cfg_div > MAX_V) wr_reload = HI_RL;
    else                      wr_reload = PCNT_W'(cfg_div - DIV_W'(1));
  end

  always_comb
    for (int i = 0; i < TCNT_W; i++) tap_mask[i] = (i < int'(tap));

  assign m_en     = src_ext_sel ? (xs[1] & ~xs[2]) : 1'b1;
  assign pre_hit  = m_en && (pcnt == reload);
  assign hit16    = pre_hit && ((tcnt & tap_mask) == tap_mask);
  assign half_hit = hit16 && (&cnt16[SUB_W-2:0]);
  assign bclk_oe  = ~bclk_dir_in;
  assign bclk_out = bclk_q & ~bclk_dir_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xs <= '0;
      bs <= '0;
    end else begin
      xs <= {xs[1:0], ext_src_in};
      bs <= {bs[1:0], bclk_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload <= PCNT_W'(DEF_DIV - 1);
      tap    <= TAP_W'(DEF_TAP);
      pcnt   <= '0;
      tcnt   <= '0;
      cnt16  <= '0;
      bclk_q <= 1'b0;
      tick16 <= 1'b0;
      tick1  <= 1'b0;
    end else if (cfg_we) begin
      reload <= wr_reload;
      tap    <= cfg_tap;
      pcnt   <= '0;
      tcnt   <= '0;
      cnt16  <= '0;
      bclk_q <= 1'b0;
      tick16 <= 1'b0;
      tick1  <= 1'b0;
    end else begin
      if (m_en) pcnt <= pre_hit ? '0 : pcnt + 1'b1;
      if (pre_hit) tcnt <= tcnt + 1'b1;
      if (hit16) cnt16 <= cnt16 + 1'b1;
      if (half_hit) bclk_q <= ~bclk_q;
      tick16 <= hit16;
      tick1  <= bclk_dir_in ? (bs[1] & ~bs[2]) : (half_hit & ~bclk_q);
    end
  end

  // R4
  tick16_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |=> !tick16);

  // R2
  reload_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload >= LO_RL) && (reload <= HI_RL));

  // R1
  pcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= reload);

  // R6
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (pcnt == '0) && (tcnt == '0) && !tick16 && !bclk_q);

  // R5
  duty_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_q != $past(bclk_q)) |-> (tick16 || $past(cfg_we)));
endmodule

// File: tb/baud_tap_gen_test.sv
module baud_tap_gen_test;
  localparam int CLK_NS = 10;
  localparam int LIMIT  = 20000;

  logic clk = 0, rst_n = 0;
  logic src_ext_sel = 0, ext_src_in = 0, cfg_we = 0;
  logic [6:0] cfg_div = 7'd2;
  logic [2:0] cfg_tap = 3'd0;
  logic bclk_dir_in = 0, bclk_in = 0;
  logic tick16, tick1, bclk_out, bclk_oe;
  logic ext_run = 0;
  int checks = 0, failures = 0;

  always #(CLK_NS/2) clk = ~clk;

  baud_tap_gen uut (
    .clk(clk), .rst_n(rst_n), .src_ext_sel(src_ext_sel), .ext_src_in(ext_src_in),
    .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_tap(cfg_tap),
    .bclk_dir_in(bclk_dir_in), .bclk_in(bclk_in),
    .tick16(tick16), .tick1(tick1), .bclk_out(bclk_out), .bclk_oe(bclk_oe));

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      if (ext_run) ext_src_in = ~ext_src_in;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int d, input int t);
    @(negedge clk);
    cfg_div = 7'(d);
    cfg_tap = 3'(t);
    cfg_we  = 1;
    @(negedge clk);
    cfg_we  = 0;
  endtask

  task automatic wait_pulse(input bit use1, input bit skip, output int n);
    n = 0;
    if (skip) begin @(negedge clk); n = 1; end
    while (!(use1 ? tick1 : tick16) && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_high(input bit use1, input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (use1 ? tick1 : tick16) n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 tick16", int'(tick16), 0);
    chk("R9 tick1", int'(tick1), 0);
    chk("R9 bclk_out", int'(bclk_out), 0);
    chk("R9 bclk_oe", int'(bclk_oe), 1);

    // R1 and R6: every divisor at tap 0
    for (int d = 2; d <= 64; d++) begin
      wr_cfg(d, 0);
      wait_pulse(0, 0, n); chk("R6 first tick16", n, d);
      wait_pulse(0, 1, n); chk("R1 period", n, d);
    end

    // R3: every tap at two divisors
    for (int d = 2; d <= 5; d += 3)
      for (int t = 0; t < 8; t++) begin
        wr_cfg(d, t);
        p = d << t;
        wait_pulse(0, 0, n); chk("R3 first tick16", n, p);
        wait_pulse(0, 1, n); chk("R3 period", n, p);
        @(negedge clk); chk("R4 tick16 width", int'(tick16), 0);
      end

    // R2 clamping
    for (int i = 0; i < 5; i++) begin
      int code, exp;
      code = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 65 : (i == 3) ? 100 : 127;
      exp  = (code < 2) ? 2 : 64;
      wr_cfg(code, 0);
      wait_pulse(0, 0, n); chk("R2 clamp first", n, exp);
      wait_pulse(0, 1, n); chk("R2 clamp period", n, exp);
    end

    // R5 and R6: 1x strobe and duty cycle
    for (int k = 0; k < 2; k++) begin
      int d, t;
      d = (k == 0) ? 2 : 3;
      t = k;
      p = d << t;
      wr_cfg(d, t);
      chk("R6 bclk_out cleared", int'(bclk_out), 0);
      wait_pulse(1, 0, n); chk("R6 first tick1", n, 8 * p);
      chk("R5 tick1 with tick16", int'(tick16), 1);
      chk("R5 bclk rises with tick1", int'(bclk_out), 1);
      wait_pulse(1, 1, n); chk("R5 tick1 period", n, 16 * p);
      n = 0;
      while (bclk_out && n < LIMIT) begin @(negedge clk); n++; end
      chk("R5 high time", n, 8 * p);
      chk("R4 tick1 width", int'(tick1), 0);
      p = n; n = 0;
      while (!bclk_out && n < LIMIT) begin @(negedge clk); n++; end
      chk("R5 low time", n, p);
    end

    // R7 external master source, edge every 4 cycles
    src_ext_sel = 1;
    ext_run = 1;
    wr_cfg(3, 1);
    wait_pulse(0, 0, n);
    wait_pulse(0, 1, n); chk("R7 ext period", n, 24);
    wait_pulse(0, 1, n); chk("R7 ext period again", n, 24);
    ext_run = 0;
    wr_cfg(2, 0);
    count_high(0, 300, n); chk("R7 stalled source", n, 0);
    src_ext_sel = 0;

    // R8 bit clock pin as input
    wr_cfg(2, 0);
    bclk_dir_in = 1;
    bclk_in = 0;
    repeat (5) @(negedge clk);
    chk("R8 bclk_oe", int'(bclk_oe), 0);
    p = 0;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (tick1) n++;
      if (bclk_out) p++;
    end
    chk("R8 no internal tick1", n, 0);
    chk("R8 bclk_out quiet", p, 0);
    bclk_in = 1;
    wait_pulse(1, 0, n); chk("R8 input latency", n, 3);
    @(negedge clk); chk("R8 single pulse", int'(tick1), 0);
    bclk_in = 0;
    count_high(1, 10, n); chk("R8 falling edge ignored", n, 0);
    bclk_dir_in = 0;
    @(negedge clk); chk("R9 bclk_oe restored", int'(bclk_oe), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule